// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the register face of a small serial port. It sits on a simple register bus that carries an address, a write enable, write data and read data, with no read strobe. It decodes its own select from the top four address bits and holds four word registers: a data register, a baud divisor, a status word and a control word. It drives a byte serializer through a start pulse and a byte, and it takes finished bytes from a deserializer.

Because the bus has no read strobe, a read only returns values. It never acknowledges anything. Receive and transmit events are sticky flags that software clears by writing 1 to them. A single level interrupt is formed from those flags and from two enables that live inside the block. Software can therefore silence the port without touching the processor's own interrupt mask.

A live "holding register empty" bit lets a polling driver spin on the status word without any acknowledge.

Top module: `uart_csr_front`

## Requirements
- R1: The block is selected when `csr_addr[ADDR_W-1:ADDR_W-4]` equals `BASE_SEL`. The word offset is `csr_addr[1:0]`. A write strobe is select AND `csr_we`. A write that is not selected changes nothing, and a read that is not selected returns 0.
- R2: Read data appears on `csr_rdata` one clock after the address. The layout is: offset 0 gives the last received byte in bits [7:0]; offset 1 gives the divisor, zero-extended; offset 2 gives the status word; offset 3 gives the control word. All unused bits read 0.
- R3: A read of any offset changes no state. In particular, reading offset 0 leaves the receive flag and the interrupt unchanged.
- R4: A write to offset 0 while the holding register is empty loads `csr_wdata[7:0]` and clears status bit 0 (empty). A write to offset 0 while the holding register is full is dropped.
- R5: While the holding register is full and `tx_busy` is 0, `tx_start` is 1 and `tx_byte` shows the held byte. In the cycle after that, status bit 0 reads 1 again.
- R6: A `rx_done` pulse sets status bit 1 (receive event) and captures `rx_byte` into the data register.
- R7: A `tx_finish` pulse sets status bit 2 (transmit done) only when the holding register is empty. If a byte is still pending, the pulse leaves bit 2 clear.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag, and writing 0 leaves it unchanged. If a set and a clear hit the same flag in the same cycle, the set wins.
- R9: Control bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt. `irq` = (bit1 AND transmit done) OR (bit0 AND receive event), and it is a level output.
- R10: `divisor` resets to `DIV_RESET`. A write to offset 1 loads `csr_wdata[DIV_W-1:0]`, which then appears on `divisor` and reads back at offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W | Bus word address |
| csr_we | input | 1 | Bus write enable |
| csr_wdata | input | 32 | Bus write data |
| csr_rdata | output | 32 | Registered bus read data |
| tx_start | output | 1 | Start a byte on the serializer |
| tx_byte | output | 8 | Byte for the serializer |
| tx_busy | input | 1 | Serializer is shifting a byte |
| tx_finish | input | 1 | Serializer completed a byte (pulse) |
| rx_done | input | 1 | Deserializer received a byte (pulse) |
| rx_byte | input | 8 | Received byte |
| divisor | output | DIV_W | Baud tick divisor |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: ADDR_W=14, BASE_SEL=4'hA, DIV_W=16 and DIV_RESET=27. With an address this narrow, the bench can form both a matching select and a neighbour select (4'h4) that differs only in the top bits. It uses the neighbour to show that foreign reads return zero and foreign writes are lost. Because `tx_busy` and `tx_finish` are driven directly, a byte can be held pending while a finish pulse arrives. That brings both the blocked transmit-done case and the dropped second write within reach, alongside a set-versus-clear collision on the receive flag.

// File: rtl/uart_csr_front.sv
module uart_csr_front #(
  parameter int          ADDR_W    = 14,
  parameter logic [3:0]  BASE_SEL  = 4'hA,
  parameter int          DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              tx_start,
  output logic [7:0]        tx_byte,
  input  logic              tx_busy,
  input  logic              tx_finish,
  input  logic              rx_done,
  input  logic [7:0]        rx_byte,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);

  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_DIV  = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;
  localparam logic [1:0] OFF_CTRL = 2'd3;

  logic       sel, wstb;
  logic [1:0] off;
  logic [7:0] hold_q, rx_q;
  logic       hold_full, rx_ev, tx_done, rx_ie, tx_ie;
  logic       thre;

  assign sel  = csr_addr[ADDR_W-1:ADDR_W-4] == BASE_SEL;
  assign off  = csr_addr[1:0];
  assign wstb = sel & csr_we;
  assign thre = ~hold_full;

  logic unused_bits;
  assign unused_bits = ^{csr_wdata[31:DIV_W], csr_addr[ADDR_W-5:2]};

  assign tx_start = hold_full & ~tx_busy;
  assign tx_byte  = hold_q;
  assign irq      = (tx_ie & tx_done) | (rx_ie & rx_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (wstb && off == OFF_DATA && !hold_full) begin
      hold_full <= 1'b1;
      hold_q    <= csr_wdata[7:0];
    end else if (tx_start) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ev   <= 1'b0;
      tx_done <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (rx_done) begin
        rx_ev <= 1'b1;
        rx_q  <= rx_byte;
      end else if (wstb && off == OFF_STAT && csr_wdata[1]) begin
        rx_ev <= 1'b0;
      end
      if (tx_finish && !hold_full) tx_done <= 1'b1;
      else if (wstb && off == OFF_STAT && csr_wdata[2]) tx_done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ie   <= 1'b0;
      tx_ie   <= 1'b0;
      divisor <= DIV_RESET;
    end else if (wstb) begin
      if (off == OFF_CTRL) begin
        rx_ie <= csr_wdata[0];
        tx_ie <= csr_wdata[1];
      end
      if (off == OFF_DIV) divisor <= csr_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_rdata <= '0;
    else if (!sel) csr_rdata <= '0;
    else begin
      case (off)
        OFF_DATA: csr_rdata <= {24'b0, rx_q};
        OFF_DIV:  csr_rdata <= 32'(divisor);
        OFF_STAT: csr_rdata <= {29'b0, tx_done, rx_ev, thre};
        default:  csr_rdata <= {30'b0, tx_ie, rx_ie};
      endcase
    end
  end

  p_rx_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_ev);

  p_rx_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ev && !csr_we) |=> rx_ev);

  p_tx_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !csr_we) |=> tx_done);

  p_w1c_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb && off == OFF_STAT && csr_wdata[1] && !rx_done) |=> !rx_ev);

  p_ctrl_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb |=> ($stable(rx_ie) && $stable(tx_ie) && $stable(divisor)));

  p_start_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !(wstb && off == OFF_DATA)) |=> thre);

  p_done_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_finish && hold_full && !tx_done) |=> !tx_done);

  p_foreign_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> csr_rdata == 32'd0);

endmodule

// File: tb/uart_csr_front_tb.sv
module uart_csr_front_tb;
  localparam int ADDR_W = 14;
  localparam logic [3:0] BASE = 4'hA;
  localparam logic [3:0] OTHER = 4'h4;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] csr_addr = '0;
  logic csr_we = 0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic tx_start, tx_busy = 0, tx_finish = 0, rx_done = 0, irq;
  logic [7:0] tx_byte, rx_byte = '0;
  logic [15:0] divisor;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  uart_csr_front u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .tx_start(tx_start),
    .tx_byte(tx_byte), .tx_busy(tx_busy), .tx_finish(tx_finish),
    .rx_done(rx_done), .rx_byte(rx_byte), .divisor(divisor), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(logic [3:0] s, logic [1:0] o);
    return {s, 8'h00, o};
  endfunction

  task automatic wr(logic [3:0] s, logic [1:0] o, logic [31:0] d);
    @(negedge clk);
    csr_addr = mk(s, o); csr_we = 1; csr_wdata = d;
    @(negedge clk);
    csr_we = 0; csr_wdata = '0;
  endtask

  task automatic rd(logic [3:0] s, logic [1:0] o, output logic [31:0] v);
    @(negedge clk);
    csr_addr = mk(s, o); csr_we = 0;
    @(negedge clk);
    v = csr_rdata;
  endtask

  task automatic pulse_rx(logic [7:0] b);
    @(negedge clk);
    rx_done = 1; rx_byte = b;
    @(negedge clk);
    rx_done = 0;
  endtask

  task automatic pulse_fin();
    @(negedge clk);
    tx_finish = 1;
    @(negedge clk);
    tx_finish = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R9 irq after reset", 32'(irq), 0);
    chk("R10 divisor reset", 32'(divisor), 27);
    chk("R5 no start at reset", 32'(tx_start), 0);
    rd(BASE, 2, v); chk("R2 status reset", v, 32'h1);
    rd(BASE, 1, v); chk("R2 divisor readback", v, 27);
  endtask

  task automatic t_receive();
    logic [31:0] v;
    pulse_rx(8'hA5);
    rd(BASE, 2, v); chk("R6 rx flag set", v, 32'h3);
    rd(BASE, 0, v); chk("R6 rx byte", v, 32'hA5);
    rd(BASE, 0, v); chk("R3 second data read", v, 32'hA5);
    rd(BASE, 2, v); chk("R3 flag kept after data read", v, 32'h3);
    chk("R9 irq disabled", 32'(irq), 0);
  endtask

  task automatic t_rx_irq();
    logic [31:0] v;
    wr(BASE, 3, 32'hFFFF_FFFD);
    chk("R9 rx irq on", 32'(irq), 1);
    rd(BASE, 3, v); chk("R2 ctrl unused bits zero", v, 32'h1);
    rd(BASE, 0, v); chk("R3 irq held after read", 32'(irq), 1);
    wr(BASE, 2, 32'h0); chk("R8 write 0 keeps flag", 32'(irq), 1);
    wr(BASE, 2, 32'h2); chk("R8 w1c clears rx", 32'(irq), 0);
    rd(BASE, 2, v); chk("R8 status after clear", v, 32'h1);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    @(negedge clk);
    csr_addr = mk(BASE, 2); csr_we = 1; csr_wdata = 32'h2;
    rx_done = 1; rx_byte = 8'h11;
    @(negedge clk);
    csr_we = 0; rx_done = 0;
    rd(BASE, 2, v); chk("R8 set beats clear", v, 32'h3);
    wr(BASE, 2, 32'h2);
    rd(BASE, 2, v); chk("R8 cleared afterwards", v, 32'h1);
  endtask

  task automatic t_transmit();
    logic [31:0] v;
    tx_busy = 1;
    wr(BASE, 0, 32'h3C);
    rd(BASE, 2, v); chk("R4 thre drops", v, 32'h0);
    chk("R5 held while busy", 32'(tx_start), 0);
    wr(BASE, 0, 32'h55);
    pulse_fin();
    rd(BASE, 2, v); chk("R7 finish blocked by pending", v, 32'h0);
    @(negedge clk);
    tx_busy = 0; #1;
    chk("R5 start on idle", 32'(tx_start), 1);
    chk("R4 first byte kept", 32'(tx_byte), 32'h3C);
    @(negedge clk);
    tx_busy = 1;
    chk("R5 start one cycle", 32'(tx_start), 0);
    rd(BASE, 2, v); chk("R5 thre back", v, 32'h1);
    pulse_fin();
    rd(BASE, 2, v); chk("R7 tx done set", v, 32'h5);
    wr(BASE, 3, 32'h2); chk("R9 tx irq on", 32'(irq), 1);
    wr(BASE, 2, 32'h4); chk("R8 w1c clears tx", 32'(irq), 0);
    tx_busy = 0;
  endtask

  task automatic t_select_div();
    logic [31:0] v;
    wr(OTHER, 3, 32'h3);
    rd(BASE, 3, v); chk("R1 foreign write ignored", v, 32'h2);
    wr(OTHER, 1, 32'h99);
    chk("R1 foreign divisor write", 32'(divisor), 27);
    rd(OTHER, 1, v); chk("R1 foreign read zero", v, 32'h0);
    wr(BASE, 1, 32'hDEAD_0104);
    chk("R10 divisor out", 32'(divisor), 32'h0104);
    rd(BASE, 1, v); chk("R10 divisor readback", v, 32'h0104);
  endtask

  initial begin
    #50000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_receive();
    t_rx_irq();
    t_set_wins();
    t_transmit();
    t_select_div();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule